// File: doc/BRIEF.md
# Multi-CPU Interrupt Mask Unit

This block collects up to 64 level-sensitive device interrupt lines into one shared request vector and gives each of four processors its own 64-bit enable mask. A processor's interrupt output is high whenever any request bit that its mask enables is set. One request bit is not taken from the device bus. It comes from the output of a cascaded legacy interrupt controller.

Software reaches the block through a 64-bit register port. Each access is a single-cycle request, and the response follows one cycle later. For each processor the port exposes the mask, which can be read and written, and a read-only view of the mask ANDed with the requests. It also exposes the raw request vector. Some reserved offsets accept accesses and do nothing with them. Offsets that are not mapped, and accesses that are not a full 8 bytes, get an error response. A per-processor presence input keeps the output of an empty processor slot low.

Top module: `irq_mask_hub`

## Requirements
- R1: While reset is held, every mask and request bit is zero, every `cpu_irq` bit is low, and `rsp_valid`, `rsp_err` and `rsp_rdata` are zero.
- R2: Each request bit other than bit 55 is captured from `dev_irq` at every clock edge. The bit reads 1 at offset 0x300 while its line is high and 0 once the line is low.
- R3: Request bit 55 is taken from `cascade_irq`. The value of `dev_irq[55]` has no effect on the request vector or on any output.
- R4: `cpu_irq[n]` is the OR-reduction of mask n AND the request vector. It is updated at the same clock edge that captures the line change or the mask write, so it changes one cycle after the cause.
- R5: When `cpu_present[n]` is 0 at an edge, `cpu_irq[n]` is low after that edge, whatever mask n holds.
- R6: The masks of CPU0, CPU1, CPU2 and CPU3 are at offsets 0x200, 0x240, 0x600 and 0x640. Each can be written and read back in all 64 bits.
- R7: Offsets 0x280, 0x2C0, 0x680 and 0x6C0 read mask n AND the request vector for CPU0 to CPU3.
- R8: Writes to the four masked views and to 0x300 complete without error and change no mask.
- R9: The reserved offsets complete without error, read zero and discard writes. They are 0x000, 0x040, 0x080, 0x0C0, 0x100 to 0x1C0, 0x340, 0x380, 0x3C0, 0x400 to 0x4C0, 0x580, 0x5C0, 0x700, 0x740, 0x780 and 0xC00 to 0xCC0, all in steps of 0x40.
- R10: An access whose byte enables are not all ones gets an error response with zero read data and writes nothing.
- R11: Any other offset, including one that is not a multiple of 0x40, gets an error response with zero read data and writes nothing.
- R12: `rsp_valid` is high exactly one cycle after `acc_valid`. The read data reflects the state that was present before the edge that accepted the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_irq | input | 64 | Level interrupt lines, one per request bit |
| cascade_irq | input | 1 | Cascaded legacy controller output, drives request bit 55 |
| cpu_present | input | 4 | Marks each CPU slot as populated |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_be | input | 8 | Byte enables; only all ones is legal |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Level interrupt to each CPU |

## Verification
The masks are set so that each one picks out a different class of request: a single low bit, only the cascade bit, every bit, and the two extreme bits together. Toggling one line at a time then shows whether each request bit is routed to the right CPU outputs. Driving `dev_irq[55]` and `cascade_irq` to opposite values shows whether bit 55 comes from the correct source. An all-ones mask on an absent slot separates the presence gating from the mask logic. A long stretch of random lines and random accesses, spread over mapped, reserved, unmapped and partial-width cases, exercises every decode path against the same-cycle timing of outputs and reads.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NCPU = 4;

  typedef enum logic [2:0] {
    ACC_ERR,
    ACC_ZERO,
    ACC_MASK,
    ACC_VIEW,
    ACC_RAW
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [1:0] cpu;
  } acc_dec_t;
endpackage

// File: rtl/irqm_decode.sv
module irqm_decode
  import irqm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BE_W   = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output acc_dec_t          dec
);
  localparam int SLOT_LSB = 6;

  logic [5:0] slot;
  logic       aligned;
  logic       in_range;

  always_comb begin
    slot     = addr[SLOT_LSB +: 6];
    aligned  = (addr[SLOT_LSB-1:0] == '0);
    in_range = ((addr >> 12) == '0);
    dec.cpu  = {addr[10], addr[6]};
    dec.kind = ACC_ERR;
    if (be == '1 && aligned && in_range) begin
      case (slot)
        6'd8, 6'd9, 6'd24, 6'd25:   dec.kind = ACC_MASK;
        6'd10, 6'd11, 6'd26, 6'd27: dec.kind = ACC_VIEW;
        6'd12:                      dec.kind = ACC_RAW;
        6'd0, 6'd1, 6'd2, 6'd3,
        6'd4, 6'd5, 6'd6, 6'd7,
        6'd13, 6'd14, 6'd15,
        6'd16, 6'd17, 6'd18, 6'd19,
        6'd22, 6'd23,
        6'd28, 6'd29, 6'd30,
        6'd48, 6'd49, 6'd50, 6'd51: dec.kind = ACC_ZERO;
        default:                    dec.kind = ACC_ERR;
      endcase
    end
  end
endmodule

// File: rtl/irqm_req_latch.sv
module irqm_req_latch #(
  parameter int W        = 64,
  parameter int CASC_BIT = 55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic         cascade,
  output logic [W-1:0] req_d,
  output logic [W-1:0] req_q
);
  always_comb begin
    req_d           = lines;
    req_d[CASC_BIT] = cascade;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  always_comb begin
    mask_d = mask_q;
    if (we) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_mask_hub.sv
module irq_mask_hub
  import irqm_pkg::*;
#(
  parameter int REQ_W    = 64,
  parameter int ADDR_W   = 12,
  parameter int CASC_BIT = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REQ_W-1:0]  dev_irq,
  input  logic              cascade_irq,
  input  logic [3:0]        cpu_present,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_be,
  input  logic [REQ_W-1:0]  acc_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [REQ_W-1:0]  rsp_rdata,
  output logic [3:0]        cpu_irq
);
  localparam int BE_W = REQ_W / 8;

  acc_dec_t                      dec;
  logic [REQ_W-1:0]              req_d, req_q;
  logic [NCPU-1:0][REQ_W-1:0]    mask_d, mask_q;
  logic [NCPU-1:0]               mask_we;
  logic [NCPU-1:0]               irq_d, irq_q;
  logic                          rsp_valid_d, rsp_err_d;
  logic [REQ_W-1:0]              rdata_d;
  logic                          rsp_valid_q, rsp_err_q;
  logic [REQ_W-1:0]              rdata_q;

  irqm_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .addr (acc_addr),
    .be   (acc_be),
    .dec  (dec)
  );

  irqm_req_latch #(.W(REQ_W), .CASC_BIT(CASC_BIT)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (dev_irq),
    .cascade (cascade_irq),
    .req_d   (req_d),
    .req_q   (req_q)
  );

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    assign mask_we[n] = acc_valid && acc_write && (dec.kind == ACC_MASK)
                        && (dec.cpu == n[1:0]);

    irqm_mask_reg #(.W(REQ_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mask_we[n]),
      .wdata  (acc_wdata),
      .mask_d (mask_d[n]),
      .mask_q (mask_q[n])
    );

    assign irq_d[n] = cpu_present[n] && ((mask_d[n] & req_d) != '0);
  end

  always_comb begin
    rsp_valid_d = acc_valid;
    rsp_err_d   = acc_valid && (dec.kind == ACC_ERR);
    rdata_d     = '0;
    if (acc_valid && !acc_write) begin
      case (dec.kind)
        ACC_MASK: rdata_d = mask_q[dec.cpu];
        ACC_VIEW: rdata_d = mask_q[dec.cpu] & req_q;
        ACC_RAW:  rdata_d = req_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      irq_q       <= irq_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rdata_q     <= rdata_d;
    end
  end

  assign cpu_irq   = irq_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int REQ_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REQ_W-1:0] dev_irq,
  input logic             cascade_irq,
  input logic [3:0]       cpu_present,
  input logic             acc_valid,
  input logic [7:0]       acc_be,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [REQ_W-1:0] rsp_rdata,
  input logic [3:0]       cpu_irq
);
  for (genvar n = 0; n < 4; n++) begin : g_abs
    p_absent_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_present[n] |=> !cpu_irq[n]);
  end

  p_no_req_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0 && !cascade_irq) |=> (cpu_irq == 4'b0));

  p_rsp_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);

  p_partial_is_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_be != 8'hFF) |=> rsp_err);

  p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
endmodule

bind irq_mask_hub irqm_chk #(.REQ_W(REQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_irq     (dev_irq),
  .cascade_irq (cascade_irq),
  .cpu_present (cpu_present),
  .acc_valid   (acc_valid),
  .acc_be      (acc_be),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .cpu_irq     (cpu_irq)
);

// File: tb/sim_irq_mask_hub.sv
`timescale 1ns/1ps
module sim_irq_mask_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] dev_irq;
  logic        cascade_irq;
  logic [3:0]  cpu_present;
  logic        acc_valid, acc_write;
  logic [11:0] acc_addr;
  logic [7:0]  acc_be;
  logic [63:0] acc_wdata;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  always #2 clk = ~clk;

  irq_mask_hub u0 (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cascade_irq(cascade_irq),
    .cpu_present(cpu_present), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cpu_irq(cpu_irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference state
  logic [63:0] m_mask [4];
  logic [63:0] m_req;
  logic [3:0]  m_irq;
  bit          m_rv, m_err;
  logic [63:0] m_rd;
  string       m_tag;

  // kind: 0 error, 1 reserved, 2 mask, 3 view, 4 raw
  function automatic int classify(input logic [11:0] a, output int c);
    c = 0;
    case (a)
      12'h200: begin c = 0; return 2; end
      12'h240: begin c = 1; return 2; end
      12'h600: begin c = 2; return 2; end
      12'h640: begin c = 3; return 2; end
      12'h280: begin c = 0; return 3; end
      12'h2C0: begin c = 1; return 3; end
      12'h680: begin c = 2; return 3; end
      12'h6C0: begin c = 3; return 3; end
      12'h300: return 4;
      12'h000, 12'h040, 12'h080, 12'h0C0, 12'h100, 12'h140, 12'h180, 12'h1C0,
      12'h340, 12'h380, 12'h3C0, 12'h400, 12'h440, 12'h480, 12'h4C0,
      12'h580, 12'h5C0, 12'h700, 12'h740, 12'h780,
      12'hC00, 12'hC40, 12'hC80, 12'hCC0: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mask[i]) m_mask[i] = '0;
      m_req = '0; m_irq = '0; m_rv = 0; m_err = 0; m_rd = '0; m_tag = "R1";
    end else begin
      int k, c;
      m_rv = acc_valid; m_err = 0; m_rd = '0; m_tag = "R12";
      if (acc_valid) begin
        k = classify(acc_addr, c);
        if (acc_be != 8'hFF) begin
          m_err = 1; m_tag = "R10";
        end else if (k == 0) begin
          m_err = 1; m_tag = "R11";
        end else if (!acc_write) begin
          case (k)
            1: begin m_rd = '0; m_tag = "R9"; end
            2: begin m_rd = m_mask[c]; m_tag = "R6"; end
            3: begin m_rd = m_mask[c] & m_req; m_tag = "R7"; end
            default: begin m_rd = m_req; m_tag = "R2,R3"; end
          endcase
        end else begin
          if (k == 2) m_mask[c] = acc_wdata;
          m_tag = (k == 1) ? "R9" : (k == 2) ? "R6" : "R8";
        end
      end
      m_req = dev_irq;
      m_req[55] = cascade_irq;
      for (int n = 0; n < 4; n++)
        m_irq[n] = cpu_present[n] && ((m_mask[n] & m_req) != 0);
    end
    #1;
    if (!done) begin
      for (int n = 0; n < 4; n++)
        chk(cpu_irq[n] === m_irq[n], cpu_present[n] ? "R4" : "R5",
            64'(cpu_irq[n]), 64'(m_irq[n]));
      chk(rsp_valid === m_rv, "R12", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk(rsp_err === m_err, m_tag, 64'(rsp_err), 64'(m_err));
        chk(rsp_rdata === m_rd, m_tag, rsp_rdata, m_rd);
      end
    end
  end

  task automatic acc(input bit wr, input logic [11:0] a, input logic [7:0] be,
                     input logic [63:0] d);
    acc_valid = 1; acc_write = wr; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; acc_be = 8'hFF; acc_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [11:0] ADDRS [20] = '{
    12'h200, 12'h240, 12'h600, 12'h640, 12'h280, 12'h2C0, 12'h680, 12'h6C0,
    12'h300, 12'h000, 12'h0C0, 12'h440, 12'hC80, 12'h780, 12'h500, 12'h7C0,
    12'h204, 12'hFC0, 12'h380, 12'h540};

  initial begin
    rst_n = 0; dev_irq = '0; cascade_irq = 0; cpu_present = 4'hF;
    acc_valid = 0; acc_write = 0; acc_addr = '0; acc_be = 8'hFF; acc_wdata = '0;
    dev_irq = 64'hFFFF_FFFF_FFFF_FFFF;
    idle(3);
    // R1: reset state with lines active
    chk(cpu_irq == 4'b0, "R1", 64'(cpu_irq), 64'd0);
    chk(rsp_valid == 0 && rsp_err == 0, "R1", 64'({rsp_valid, rsp_err}), 64'd0);
    chk(rsp_rdata == '0, "R1", rsp_rdata, 64'd0);
    dev_irq = '0;
    rst_n = 1;
    idle(2);
    acc(0, 12'h200, 8'hFF, '0);           // R1: masks read zero
    acc(0, 12'h300, 8'hFF, '0);
    // R6: program masks
    acc(1, 12'h200, 8'hFF, 64'h8);
    acc(1, 12'h240, 8'hFF, 64'h0080_0000_0000_0000);
    acc(1, 12'h600, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(1, 12'h640, 8'hFF, 64'h8000_0000_0000_0001);
    acc(0, 12'h200, 8'hFF, '0); acc(0, 12'h240, 8'hFF, '0);
    acc(0, 12'h600, 8'hFF, '0); acc(0, 12'h640, 8'hFF, '0);
    // R4 / R2: single line toggles
    dev_irq[3] = 1; idle(2); acc(0, 12'h300, 8'hFF, '0); acc(0, 12'h280, 8'hFF, '0);
    dev_irq[3] = 0; idle(2); acc(0, 12'h300, 8'hFF, '0);
    dev_irq[0] = 1; idle(2); dev_irq[0] = 0;
    dev_irq[63] = 1; idle(2); dev_irq[63] = 0; idle(1);
    // R3: bit 55 follows cascade, not the device line
    dev_irq[55] = 1; cascade_irq = 0; idle(2); acc(0, 12'h300, 8'hFF, '0);
    acc(0, 12'h2C0, 8'hFF, '0);
    dev_irq[55] = 0; cascade_irq = 1; idle(2); acc(0, 12'h300, 8'hFF, '0);
    acc(0, 12'h2C0, 8'hFF, '0);
    // R5: absent slot with all-ones mask
    cpu_present = 4'b1011; idle(3); cpu_present = 4'hF; idle(2);
    cascade_irq = 0;
    // R8: ignored writes, then masks re-read
    dev_irq = 64'h00FF_0000_0000_0009;
    acc(1, 12'h280, 8'hFF, 64'h1234); acc(1, 12'h6C0, 8'hFF, 64'h5678);
    acc(1, 12'h300, 8'hFF, '1);
    acc(0, 12'h200, 8'hFF, '0); acc(0, 12'h640, 8'hFF, '0); acc(0, 12'h300, 8'hFF, '0);
    // R9: reserved offsets
    acc(1, 12'h040, 8'hFF, '1); acc(0, 12'h040, 8'hFF, '0);
    acc(0, 12'h1C0, 8'hFF, '0); acc(1, 12'h4C0, 8'hFF, '1); acc(0, 12'hCC0, 8'hFF, '0);
    // R10: partial width, write must not land
    acc(1, 12'h200, 8'h0F, 64'hDEAD); acc(0, 12'h200, 8'h7F, '0);
    acc(0, 12'h200, 8'hFF, '0);
    // R11: unmapped and misaligned
    acc(1, 12'h204, 8'hFF, 64'hBEEF); acc(0, 12'h500, 8'hFF, '0);
    acc(0, 12'h7C0, 8'hFF, '0); acc(0, 12'h200, 8'hFF, '0);
    // R12: back-to-back accesses
    acc(0, 12'h600, 8'hFF, '0); acc(0, 12'h680, 8'hFF, '0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      dev_irq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cascade_irq = $urandom_range(0, 1);
      cpu_present = 4'($urandom);
      if ($urandom_range(0, 2) != 0)
        acc($urandom_range(0, 1), ADDRS[$urandom_range(0, 19)],
            ($urandom_range(0, 7) == 0) ? 8'h3F : 8'hFF, {$urandom, $urandom});
      else
        idle(1);
    end
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule